// File: doc/BRIEF.md
# Paged CSR window decoder

This block sits between a simple read/write register bus with 16-bit offsets and a register file that spans a full 64 KB offset space. The bus reaches most of that space through a 1 KB direct window. An access whose offset carries the window pattern (bits 11:10 both set) is redirected. The page number held in a local control register supplies the upper six offset bits, and the low ten bits of the access supply the rest. Any other offset goes to the register file unchanged.

To reach a paged register, software first writes the page number into the control register. It then issues the access through the window. The same control register holds two independent enable bits. These are brought out as pins: one enables the host-side programmed I/O path and one enables the link-side programmed I/O path.

Reads are answered one cycle after the request. Writes produce a single-cycle strobe toward the register file in the cycle of the request. An effective offset at or above a configurable limit counts as unmapped. Such an access produces no strobe, and a read of it returns zero.

Top module: `csr_page_window`

## Requirements
- R1: After reset the control register reads 0, both enable outputs are 0 and the page is 0.
- R2: A write to the control offset (default 0x0008, reached only directly, never through the window) stores bits 18:13 (page) and bits 1:0 (enables). All other bits read back as 0. A read of the control offset returns the stored value.
- R3: `host_pio_en` follows control bit 0 and `link_pio_en` follows control bit 1, starting the cycle after the write.
- R4: When offset bits 11:10 are both 1, the register file sees offset {page, access[9:0]}. Bits 15:12 of the access have no effect on that offset.
- R5: When offset bits 11:10 are not both 1, the register file sees the access offset unchanged, with no page applied.
- R6: A control write in one cycle changes the page used by a windowed access issued in the very next cycle.
- R7: A write to a mapped offset raises `rf_wr` in the request cycle, with `rf_wdata` equal to the bus data. A control write or an unmapped write raises no strobe.
- R8: A read of a mapped offset raises `rf_rd` in the request cycle. The next cycle, `rsp_valid` is 1 and `rsp_rdata` holds the register file data.
- R9: An effective offset at or above RF_LIMIT (default 0xE000) raises no strobe. A read of it returns 0 with `rsp_valid` and no error.
- R10: An access to the control offset is not forwarded to the register file. A windowed access whose low bits match the control offset does go to the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Bus offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after the read) |
| rsp_rdata | output | 32 | Read data |
| rf_addr | output | 16 | Effective register file offset |
| rf_wr | output | 1 | Register file write strobe |
| rf_rd | output | 1 | Register file read strobe |
| rf_wdata | output | 32 | Register file write data |
| rf_rdata | input | 32 | Register file read data, valid in the strobe cycle |
| host_pio_en | output | 1 | Host-side programmed I/O enable (control bit 0) |
| link_pio_en | output | 1 | Link-side programmed I/O enable (control bit 1) |

## Verification
The hardest case to reach is a page change immediately followed by a windowed access. In that case a stale page would go unnoticed unless the two requests are back to back. The stimulus therefore issues a control write and, in the very next cycle, a windowed write and read.

The stimulus also puts pages on both sides of the unmapped limit, with in-window offsets at the top of the page. This checks that the limit is applied to the remapped offset rather than the raw one.

Windowed offsets with junk in bits 15:12, and a windowed alias of the control offset, show that only bits 11:10 select the window.

// File: rtl/csr_page_pkg.sv
package csr_page_pkg;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_CTRL  = 2'd1,
        TGT_RFILE = 2'd2
    } tgt_e;

    // window pattern: both select bits set
    function automatic logic is_window(input logic [1:0] sel);
        return sel == 2'b11;
    endfunction

endpackage

// File: rtl/csr_page_reg.sv
module csr_page_reg
    import csr_page_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int PAGE_W   = 6,
    parameter int PAGE_LSB = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [PAGE_W-1:0] page,
    output logic              en_host,
    output logic              en_link
);
    localparam logic [DATA_W-1:0] PAGE_MSK =
        {{(DATA_W-PAGE_W){1'b0}}, {PAGE_W{1'b1}}} << PAGE_LSB;
    localparam logic [DATA_W-1:0] KEEP_MSK = PAGE_MSK | DATA_W'(3);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr_en)
            ctrl_q <= wdata & KEEP_MSK;
    end

    assign page    = ctrl_q[PAGE_LSB +: PAGE_W];
    assign en_host = ctrl_q[0];
    assign en_link = ctrl_q[1];
endmodule

// File: rtl/csr_addr_route.sv
module csr_addr_route
    import csr_page_pkg::*;
#(
    parameter int PAGE_W   = 6,
    parameter int LOW_W    = 10,
    parameter int CTRL_OFS = 'h0008,
    parameter int RF_LIMIT = 'hE000
) (
    input  logic [PAGE_W+LOW_W-1:0] addr,
    input  logic [PAGE_W-1:0]       page,
    output tgt_e                    tgt,
    output logic [PAGE_W+LOW_W-1:0] eff
);
    localparam int ADDR_W = PAGE_W + LOW_W;

    logic win;

    always_comb begin
        win = is_window(addr[LOW_W +: 2]);
        eff = win ? {page, addr[LOW_W-1:0]} : addr;
        if (!win && addr == ADDR_W'(CTRL_OFS))
            tgt = TGT_CTRL;
        else if ({1'b0, eff} < (ADDR_W+1)'(RF_LIMIT))
            tgt = TGT_RFILE;
        else
            tgt = TGT_NONE;
    end
endmodule

// File: rtl/csr_read_return.sv
module csr_read_return
    import csr_page_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_fire,
    input  tgt_e              tgt,
    input  logic [DATA_W-1:0] rf_rdata,
    input  logic [DATA_W-1:0] ctrl_q,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic [DATA_W-1:0] sel_data;

    always_comb begin
        unique case (tgt)
            TGT_CTRL:  sel_data = ctrl_q;
            TGT_RFILE: sel_data = rf_rdata;
            default:   sel_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_fire;
            rsp_rdata <= rd_fire ? sel_data : '0;
        end
    end
endmodule

// File: rtl/csr_page_window.sv
module csr_page_window
    import csr_page_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int PAGE_W   = 6,
    parameter int LOW_W    = 10,
    parameter int PAGE_LSB = 13,
    parameter int CTRL_OFS = 'h0008,
    parameter int RF_LIMIT = 'hE000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [PAGE_W+LOW_W-1:0] req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic                    rsp_valid,
    output logic [DATA_W-1:0]       rsp_rdata,
    output logic [PAGE_W+LOW_W-1:0] rf_addr,
    output logic                    rf_wr,
    output logic                    rf_rd,
    output logic [DATA_W-1:0]       rf_wdata,
    input  logic [DATA_W-1:0]       rf_rdata,
    output logic                    host_pio_en,
    output logic                    link_pio_en
);
    localparam int ADDR_W = PAGE_W + LOW_W;

    logic [DATA_W-1:0] ctrl_q;
    logic [PAGE_W-1:0] page;
    logic [ADDR_W-1:0] eff;
    tgt_e              tgt;
    logic              ctrl_wr;
    logic              rd_fire;

    csr_addr_route #(
        .PAGE_W(PAGE_W), .LOW_W(LOW_W), .CTRL_OFS(CTRL_OFS), .RF_LIMIT(RF_LIMIT)
    ) u_route (
        .addr(req_addr), .page(page), .tgt(tgt), .eff(eff)
    );

    assign ctrl_wr = req_valid && req_write && (tgt == TGT_CTRL);
    assign rd_fire = req_valid && !req_write;

    csr_page_reg #(
        .DATA_W(DATA_W), .PAGE_W(PAGE_W), .PAGE_LSB(PAGE_LSB)
    ) u_ctrl (
        .clk(clk), .rst(rst), .wr_en(ctrl_wr), .wdata(req_wdata),
        .ctrl_q(ctrl_q), .page(page), .en_host(host_pio_en), .en_link(link_pio_en)
    );

    always_comb begin
        rf_wr    = req_valid && req_write  && (tgt == TGT_RFILE);
        rf_rd    = req_valid && !req_write && (tgt == TGT_RFILE);
        rf_addr  = (tgt == TGT_RFILE) ? eff : '0;
        rf_wdata = req_wdata;
    end

    csr_read_return #(.DATA_W(DATA_W)) u_rsp (
        .clk(clk), .rst(rst), .rd_fire(rd_fire), .tgt(tgt),
        .rf_rdata(rf_rdata), .ctrl_q(ctrl_q),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );
endmodule

// File: rtl/csr_page_window_chk.sv
module csr_page_window_chk #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 16,
    parameter int CTRL_OFS = 'h0008,
    parameter int RF_LIMIT = 'hE000
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rf_wr,
    input logic              rf_rd,
    input logic [ADDR_W-1:0] rf_addr,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] ctrl_q
);
    logic ctrl_direct;
    assign ctrl_direct = (req_addr == ADDR_W'(CTRL_OFS));

    // R7: a write strobe only comes from a bus write
    a_r7_wr_from_write: assert property (@(posedge clk) disable iff (rst)
        rf_wr |-> (req_valid && req_write));

    // R8: read data is answered one cycle after a bus read
    a_r8_rsp_after_read: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !req_write));

    // R8: the strobes never overlap
    a_r8_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(rf_wr && rf_rd));

    // R10: the direct control offset is never forwarded
    a_r10_ctrl_local: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ctrl_direct) |-> !(rf_wr || rf_rd));

    // R4: a windowed access keeps its low ten bits
    a_r4_low_bits: assert property (@(posedge clk) disable iff (rst)
        ((rf_wr || rf_rd) && req_addr[11:10] == 2'b11) |-> rf_addr[9:0] == req_addr[9:0]);

    // R9: no strobe reaches past the mapped limit
    a_r9_limit: assert property (@(posedge clk) disable iff (rst)
        (rf_wr || rf_rd) |-> ({1'b0, rf_addr} < (ADDR_W+1)'(RF_LIMIT)));

    // R2: the control register changes only on a control write
    a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write && ctrl_direct) |=> $stable(ctrl_q));
endmodule

bind csr_page_window csr_page_window_chk #(
    .DATA_W(DATA_W), .ADDR_W(PAGE_W+LOW_W), .CTRL_OFS(CTRL_OFS), .RF_LIMIT(RF_LIMIT)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .rf_wr(rf_wr), .rf_rd(rf_rd), .rf_addr(rf_addr),
    .rsp_valid(rsp_valid), .ctrl_q(ctrl_q)
);

// File: tb/tb_csr_page_window.sv
module tb_csr_page_window;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [15:0] req_addr;
    logic [31:0] req_wdata;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [15:0] rf_addr;
    logic        rf_wr, rf_rd;
    logic [31:0] rf_wdata, rf_rdata;
    logic        host_pio_en, link_pio_en;

    int n_chk = 0;
    int n_err = 0;
    int m_ctrl = 0;   // reference control register

    always #(CLK_P/2) clk = ~clk;

    // register file stand-in: data derived from the offset
    assign rf_rdata = {~rf_addr, rf_addr};

    csr_page_window dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rf_addr(rf_addr), .rf_wr(rf_wr), .rf_rd(rf_rd),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
        .host_pio_en(host_pio_en), .link_pio_en(link_pio_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int m_eff(input int a);
        if (((a >> 10) & 3) == 3) return ((m_ctrl >> 13) & 63) * 1024 + (a % 1024);
        return a;
    endfunction

    function automatic bit m_is_ctrl(input int a);
        return (((a >> 10) & 3) != 3) && (a == 8);
    endfunction

    function automatic bit m_mapped(input int a);
        return !m_is_ctrl(a) && (m_eff(a) < 'hE000);
    endfunction

    // one bus transaction, compared against the model in both cycles it touches
    task automatic op(input string req, input bit wr, input int a, input logic [31:0] d);
        int eff = m_eff(a);
        bit mp  = m_mapped(a);
        logic [31:0] exp_rd;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a[15:0]; req_wdata = d;
        #1;
        chk({req, " wr strobe"}, {31'b0, rf_wr}, {31'b0, wr && mp});
        chk({req, " rd strobe"}, {31'b0, rf_rd}, {31'b0, !wr && mp});
        if (mp) chk({req, " rf_addr"}, {16'b0, rf_addr}, eff);
        if (wr && mp) chk({req, " rf_wdata"}, rf_wdata, d);
        if (m_is_ctrl(a)) exp_rd = m_ctrl;
        else if (mp) exp_rd = {~eff[15:0], eff[15:0]};
        else exp_rd = 0;
        @(posedge clk);
        if (wr && m_is_ctrl(a)) m_ctrl = d & 32'h0007_E003;
        #1;
        req_valid = 1'b0;
        chk({req, " rsp_valid"}, {31'b0, rsp_valid}, {31'b0, !wr});
        if (!wr) chk({req, " rsp_rdata"}, rsp_rdata, exp_rd);
        chk({req, " host_pio_en"}, {31'b0, host_pio_en}, m_ctrl & 1);
        chk({req, " link_pio_en"}, {31'b0, link_pio_en}, (m_ctrl >> 1) & 1);
    endtask

    initial begin
        #(CLK_P * 20000);
        n_err++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state
        chk("R1 host_pio_en", {31'b0, host_pio_en}, 0);
        chk("R1 link_pio_en", {31'b0, link_pio_en}, 0);
        op("R1 ctrl read", 0, 'h0008, 0);
        op("R1 page0 window", 0, 'h0C20, 0);
        // R2: only page and enable bits stick
        op("R2 ctrl write all ones", 1, 'h0008, 32'hFFFF_FFFF);
        op("R2 ctrl readback", 0, 'h0008, 0);
        // R3: enables individually
        op("R3 host enable only", 1, 'h0008, 32'h0000_A001);
        op("R3 link enable only", 1, 'h0008, 32'h0000_A002);
        // R4: windowed read, page 5; junk in bits 15:12
        op("R4 window read", 0, 'h0C10, 0);
        op("R4 upper bits ignored", 0, 'hFC10, 0);
        op("R4 window write", 1, 'h0DFF, 32'h1234_5678);
        // R5: direct offsets
        op("R5 direct read", 0, 'h0410, 0);
        op("R5 direct write", 1, 'h8808, 32'hCAFE_0001);
        op("R5 direct high read", 0, 'hD3FC, 0);
        // R6: page change then immediate windowed access
        op("R6 page 0x20", 1, 'h0008, 32'h0004_0000);
        op("R6 next-cycle window write", 1, 'h0FFF, 32'hA5A5_0000);
        op("R6 next-cycle window read", 0, 'h0C01, 0);
        // R9: boundary pages
        op("R9 page 0x37", 1, 'h0008, 32'h0006_E000);
        op("R9 last mapped offset", 0, 'h0FFF, 0);
        op("R9 page 0x38", 1, 'h0008, 32'h0007_0000);
        op("R9 unmapped window read", 0, 'h0C00, 0);
        op("R9 unmapped window write", 1, 'h0C00, 32'hDEAD_BEEF);
        op("R9 unmapped direct read", 0, 'hF000, 0);
        // R7: control write is not a register file write
        op("R7 ctrl write no strobe", 1, 'h0008, 32'h0000_0003);
        // R10: windowed alias of the control offset goes to the register file
        op("R10 window alias", 0, 'h0C08, 0);
        op("R10 alias write", 1, 'h3C08, 32'h0BAD_F00D);
        op("R10 ctrl unchanged", 0, 'h0008, 0);
        // R8: idle cycle gives no response
        @(negedge clk); @(posedge clk); #1;
        chk("R8 idle rsp_valid", {31'b0, rsp_valid}, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule